// File: doc/BRIEF.md
# Fan Speed Target Register Pair

This block holds the 13-bit tachometer target for a closed-loop fan speed controller. Software reaches it through two byte-wide registers on a simple bus with an address, a write strobe, a read strobe and 8-bit data. A write to the low byte only loads a staging register. The full target changes in one step when the high byte is written: the new high byte and the staged low bits are committed together. This way the control loop never sees a target that is half old and half new.

The committed target drives two control outputs for the speed loop. While the algorithm is enabled and the target's upper byte is all ones, the block asks for 0% drive. When a commit moves the target away from that maximum while the algorithm is enabled, the block emits a one-cycle spin-up request. The loop, the PWM stage and the spin-up sequencing sit outside this block. They consume `target`, `drive_off` and `spinup_req`.

Top module: `fan_target_regs`

## Requirements
- R1: After a synchronous active-low reset, the target is 0x1FFF, a low-byte read returns 0xF8, a high-byte read returns 0xFF, and `spinup_req` is 0.
- R2: A write to address 0x3D sets the target, from the next clock edge, to {written byte, staged 5 low bits}. The high byte maps to target bits 12..5.
- R3: A write to address 0x3C changes neither `target` nor any read-back value. It only updates the staging register from data bits 7..3, which map to target bits 4..0.
- R4: With `bus_rd` high, address 0x3D returns target bits 12..5 and address 0x3C returns {target bits 4..0, 3'b000}. Any other address, or `bus_rd` low, returns 0x00.
- R5: `drive_off` is high exactly when `algo_en` is high and target bits 12..5 are all ones.
- R6: `spinup_req` is high for exactly one cycle, in the cycle after a high-byte write. This happens when, at that write, `algo_en` was high, the active upper byte was 0xFF, and the written byte is not 0xFF.
- R7: Data bits 2..0 of a low-byte write are ignored, and those bits read back as zero.
- R8: The staged low bits persist across high-byte writes until another low-byte write or reset. A high-byte write with no fresh low-byte write reuses the last staged value.
- R9: No spin-up request is raised if `algo_en` was low at the commit, if the upper byte was already not 0xFF, or if the written byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| algo_en | input | 1 | Speed algorithm enabled |
| target | output | 13 | Committed tachometer target |
| drive_off | output | 1 | Force 0% fan drive |
| spinup_req | output | 1 | One-cycle spin-up request |

## Verification
The checker watches several rules on every cycle: a target that stays frozen unless the high byte is written, a commit that lands the written byte in the upper target bits, zeroed pad bits on low reads, a spin-up pulse that lasts one cycle and always traces back to a qualifying commit, and `drive_off` following a commit of 0xFF. Only the bench scenarios can show the rest. These are staged low bits that survive over several commits, the exact reset values, reads that ignore a pending low write, and the cases where no spin-up is raised: algorithm disabled, already below the maximum, or rewriting the maximum.

// File: rtl/fan_tgt_pkg.sv
// Shared defaults and the decoded bus-operation type for the fan target
// register pair. Assumes one register access per cycle.
package fan_tgt_pkg;
    localparam int TGT_W_D  = 13;
    localparam int BYTE_W_D = 8;
    localparam int ADDR_W_D = 8;
    localparam logic [7:0] LO_ADDR_D = 8'h3C;
    localparam logic [7:0] HI_ADDR_D = 8'h3D;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
    } bus_op_t;
endpackage

// File: rtl/fan_tgt_decode.sv
// Address decoder: turns address and strobes into one-hot register
// operations. Assumes the bus never issues a read and a write together.
module fan_tgt_decode
    import fan_tgt_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D,
    parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(LO_ADDR_D),
    parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(HI_ADDR_D)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_op_t           op
);
    // Match the address against both register slots.
    always_comb begin
        op.wr_lo = wr && (addr == LO_ADDR);
        op.wr_hi = wr && (addr == HI_ADDR);
        op.rd_lo = rd && (addr == LO_ADDR);
        op.rd_hi = rd && (addr == HI_ADDR);
    end
endmodule

// File: rtl/fan_tgt_store.sv
// Staging register for the low target bits plus the committed target.
// The low write only stages. The high write commits both parts at once.
// Unused low data bits are dropped. Assumes TGT_W > BYTE_W.
module fan_tgt_store
    import fan_tgt_pkg::*;
#(
    parameter int TGT_W  = TGT_W_D,
    parameter int BYTE_W = BYTE_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_t           op,
    input  logic [BYTE_W-1:0] wdata,
    output logic [TGT_W-1:0]  target
);
    localparam int LO_W  = TGT_W - BYTE_W;
    localparam int PAD_W = BYTE_W - LO_W;

    logic [LO_W-1:0]  stage_q;
    logic [TGT_W-1:0] tgt_q;

    // Capture the upper data bits of a low-byte write into staging.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '1;
        else if (op.wr_lo)
            stage_q <= wdata[BYTE_W-1:PAD_W];
    end

    // Commit high byte and staged low bits together on a high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt_q <= '1;
        else if (op.wr_hi)
            tgt_q <= {wdata, stage_q};
    end

    assign target = tgt_q;
endmodule

// File: rtl/fan_tgt_ctrl.sv
// Control outputs derived from the committed target: a level that forces
// the drive off at the maximum, and a one-cycle spin-up pulse when a commit
// leaves the maximum. The maximum is judged on the upper byte only.
module fan_tgt_ctrl #(
    parameter int BYTE_W = fan_tgt_pkg::BYTE_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] target_hi,
    input  logic              algo_en,
    output logic              drive_off,
    output logic              spinup_req
);
    logic hi_at_max;
    logic new_at_max;
    logic spin_q;

    // Flag the all-ones upper byte, both current and incoming.
    always_comb begin
        hi_at_max  = &target_hi;
        new_at_max = &wdata;
    end

    // Register the spin-up pulse so it lines up with the new target.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spin_q <= 1'b0;
        else
            spin_q <= wr_hi && algo_en && hi_at_max && !new_at_max;
    end

    assign drive_off  = algo_en && hi_at_max;
    assign spinup_req = spin_q;
endmodule

// File: rtl/fan_tgt_rdmux.sv
// Read-back multiplexer: always shows the committed target, never the
// staged bits. Pad bits of the low byte read as zero.
module fan_tgt_rdmux
    import fan_tgt_pkg::*;
#(
    parameter int TGT_W  = TGT_W_D,
    parameter int BYTE_W = BYTE_W_D
) (
    input  bus_op_t           op,
    input  logic [TGT_W-1:0]  target,
    output logic [BYTE_W-1:0] rdata
);
    localparam int LO_W  = TGT_W - BYTE_W;
    localparam int PAD_W = BYTE_W - LO_W;

    // Select the addressed half of the committed target, or zero.
    always_comb begin
        if (op.rd_hi)
            rdata = target[TGT_W-1:LO_W];
        else if (op.rd_lo)
            rdata = {target[LO_W-1:0], {PAD_W{1'b0}}};
        else
            rdata = '0;
    end
endmodule

// File: rtl/fan_target_regs.sv
// Top of the fan target register pair: decode, staged commit, read-back
// and control outputs. Synchronous active-low reset to the maximum target.
module fan_target_regs
    import fan_tgt_pkg::*;
#(
    parameter int TGT_W  = TGT_W_D,
    parameter int BYTE_W = BYTE_W_D,
    parameter int ADDR_W = ADDR_W_D,
    parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(LO_ADDR_D),
    parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(HI_ADDR_D)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              algo_en,
    output logic [TGT_W-1:0]  target,
    output logic              drive_off,
    output logic              spinup_req
);
    localparam int LO_W = TGT_W - BYTE_W;

    bus_op_t op;

    fan_tgt_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .op   (op)
    );

    fan_tgt_store #(.TGT_W(TGT_W), .BYTE_W(BYTE_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wdata  (bus_wdata),
        .target (target)
    );

    fan_tgt_rdmux #(.TGT_W(TGT_W), .BYTE_W(BYTE_W)) u_rd (
        .op     (op),
        .target (target),
        .rdata  (bus_rdata)
    );

    fan_tgt_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (op.wr_hi),
        .wdata      (bus_wdata),
        .target_hi  (target[TGT_W-1:LO_W]),
        .algo_en    (algo_en),
        .drive_off  (drive_off),
        .spinup_req (spinup_req)
    );
endmodule

// File: rtl/fan_tgt_chk.sv
// Checker for the fan target register pair, bound to the top module.
// Observes ports only and uses the default parameter set.
module fan_tgt_chk
    import fan_tgt_pkg::*;
#(
    parameter int TGT_W  = TGT_W_D,
    parameter int BYTE_W = BYTE_W_D,
    parameter int ADDR_W = ADDR_W_D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              algo_en,
    input logic [TGT_W-1:0]  target,
    input logic              drive_off,
    input logic              spinup_req
);
    localparam int LO_W  = TGT_W - BYTE_W;
    localparam int PAD_W = BYTE_W - LO_W;
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR_D);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR_D);

    logic wr_hi, wr_lo;
    assign wr_hi = bus_wr && (bus_addr == HI_A);
    assign wr_lo = bus_wr && (bus_addr == LO_A);

    p_hi_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> target[TGT_W-1:LO_W] == $past(bus_wdata));

    p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(target));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(target));

    p_off_after_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && (&bus_wdata) && algo_en) |=> (drive_off || !algo_en));

    p_spin_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spinup_req |=> !spinup_req);

    p_spin_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spinup_req |-> $past(wr_hi && algo_en && !(&bus_wdata)));

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == LO_A) |-> bus_rdata[PAD_W-1:0] == '0);
endmodule

bind fan_target_regs fan_tgt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .algo_en    (algo_en),
    .target     (target),
    .drive_off  (drive_off),
    .spinup_req (spinup_req)
);

// File: tb/sim_fan_target_regs.sv
module sim_fan_target_regs;
    localparam int CLK_P = 10;
    localparam logic [7:0] A_LO = 8'h3C;
    localparam logic [7:0] A_HI = 8'h3D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        algo_en = 1'b0;
    logic [12:0] target;
    logic        drive_off;
    logic        spinup_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [4:0]  m_stage;
    logic [12:0] m_tgt;
    logic        m_spin;

    always #(CLK_P/2) clk = ~clk;

    fan_target_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .algo_en(algo_en), .target(target), .drive_off(drive_off),
        .spinup_req(spinup_req)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic [12:0] t);
        if (a == A_HI) return t[12:5];
        if (a == A_LO) return {t[4:0], 3'b000};
        return 8'h00;
    endfunction

    function automatic logic exp_off(input logic en, input logic [12:0] t);
        return en && (t[12:5] == 8'hFF);
    endfunction

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_stage = 5'h1F;
        m_tgt   = 13'h1FFF;
        m_spin  = 1'b0;
        check("R1 target after reset", 16'(target), 16'h1FFF);
        check("R1 spinup after reset", 16'(spinup_req), 16'h0);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        m_spin = (a == A_HI) && algo_en && (m_tgt[12:5] == 8'hFF) && (d != 8'hFF);
        if (a == A_LO) m_stage = d[7:3];
        if (a == A_HI) m_tgt = {d, m_stage};
        @(negedge clk);
        bus_wr = 1'b0;
        check(a == A_HI ? "R2 R8 target after high write" : "R3 R7 target after low write",
              16'(target), 16'(m_tgt));
        check(m_spin ? "R6 spinup pulse" : "R9 no spinup", 16'(spinup_req), 16'(m_spin));
        check("R5 drive_off", 16'(drive_off), 16'(exp_off(algo_en, m_tgt)));
        @(negedge clk);
        check("R6 spinup lasts one cycle", 16'(spinup_req), 16'h0);
    endtask

    task automatic do_read(input logic [7:0] a, input string what);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(what, 16'(bus_rdata), 16'(exp_rd(a, m_tgt)));
        bus_rd = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        algo_en = v;
        #1;
        check("R5 drive_off after enable change", 16'(drive_off), 16'(exp_off(v, m_tgt)));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        do_reset();
        do_read(A_LO, "R1 low read after reset");
        do_read(A_HI, "R1 high read after reset");
        set_en(1'b1);

        do_write(A_LO, 8'hA7);
        do_read(A_LO, "R3 low read ignores staged write");
        do_write(A_HI, 8'h12);
        do_read(A_LO, "R7 pad bits read zero");
        do_read(A_HI, "R4 high read");
        do_write(A_HI, 8'h34);
        do_write(A_HI, 8'hFF);
        set_en(1'b0);
        do_write(A_HI, 8'h40);
        do_write(A_HI, 8'hFF);
        set_en(1'b1);
        do_write(A_LO, 8'hFF);
        do_write(A_HI, 8'hFF);
        do_read(8'h3E, "R4 unmapped address reads zero");
        @(negedge clk);
        bus_addr = A_HI; bus_rd = 1'b0;
        #1;
        check("R4 no strobe reads zero", 16'(bus_rdata), 16'h0);

        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom % 8);
            case (sel)
                0, 1: do_write(A_LO, 8'($urandom));
                2, 3: do_write(A_HI, ($urandom % 3 == 0) ? 8'hFF : 8'($urandom));
                4:    do_read(A_LO, "R4 random low read");
                5:    do_read(A_HI, "R4 random high read");
                6:    set_en(1'($urandom));
                default: begin
                    if ($urandom % 10 == 0) begin
                        do_reset();
                        do_read(A_LO, "R1 low read after mid reset");
                    end else begin
                        do_read(8'($urandom), "R4 random address read");
                    end
                end
            endcase
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule